// File: doc/BRIEF.md
# Prioritised Interrupt Level Controller

This block decides, at each instruction boundary of a small 16-bit CPU, whether the processor must enter an interrupt service routine and through which vector. It watches seven level-sensitive hardware request lines and an eighth, unmaskable request that plays the role of a reset interrupt. It holds a 3-bit servicing level that masks every hardware request at or below the level in service. Software interrupts issued by the CPU draw on the same sixteen-entry vector table. That table sits in the sixteen highest 16-bit words of a 64 KB byte address space.

When a request is accepted, the controller pulses a take strobe and presents the vector number and vector address. The CPU then stacks its old level and condition codes and signals that the stacking is done. Only then does the controller move its level register to the new servicing level. Software changes the level with load, AND and OR operations that carry an 8-bit operand, and with a restore that reloads the popped level on return from interrupt.

Top module: `irq_level_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state has `cur_mask` = 3'b111, `take_int` = 0 and `in_entry` = 0.
- R2: Hardware request `irq_req[n]` (n = 0..6) can be accepted only when n >= `cur_mask`. A request whose level n+1 is at or below the current mask is blocked and produces no take.
- R3: `rst_req` is level 7 and is accepted whatever the mask holds. Its vector number is 7.
- R4: Among the eligible hardware requests, the highest level wins. `vec_idx` is the winner's level. `vec_addr` equals 16'hFFE0 + 2*`vec_idx`.
- R5: Requests are sampled only at a rising edge where `fetch_rdy` = 1 and `in_entry` = 0. After such an edge that accepts a request, `take_int` is 1 for exactly one cycle and `in_entry` goes to 1.
- R6: Accepting a request leaves `cur_mask` unchanged. At the rising edge where `ctx_pushed` = 1 during entry, `cur_mask` becomes n+1 for hardware level n (0..6), or 3'b111 for level 7, and `in_entry` returns to 0.
- R7: `swi_req` at a boundary with no eligible hardware request is accepted with `vec_idx` = `swi_vec` (0..15). When it commits, `cur_mask` keeps its value. If any hardware request is eligible at that boundary, the hardware request wins.
- R8: Outside entry, `mask_op` acts on `cur_mask` at the rising edge using `mask_data[2:0]`. The codes are 1 = load, 2 = AND, 3 = OR and 4 = restore (same effect as load). Codes 0 and 5 to 7 leave the mask unchanged.
- R9: During entry, `mask_op` and `fetch_rdy` have no effect. Outside entry, `ctx_pushed` has no effect.
- R10: A `mask_op` in the same cycle as a boundary is still applied. The interrupt decision at that edge uses the mask held before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 7 | Level-sensitive hardware requests, bit n = level n |
| rst_req | input | 1 | Unmaskable level-7 request |
| fetch_rdy | input | 1 | Instruction boundary, requests sampled |
| swi_req | input | 1 | Software interrupt request, held by the CPU until taken |
| swi_vec | input | 4 | Software interrupt vector number |
| mask_op | input | 3 | Mask operation code |
| mask_data | input | 8 | Mask operand, level in bits [2:0] |
| ctx_pushed | input | 1 | Old level and condition codes have been stacked |
| take_int | output | 1 | One-cycle strobe: interrupt accepted |
| vec_idx | output | 4 | Accepted vector number |
| vec_addr | output | 16 | Address of the vector word |
| cur_mask | output | 3 | Current servicing level |
| in_entry | output | 1 | Waiting for the context push to finish |

## Verification
A wrong servicing level shows up at the first boundary after it forms. Either a request that should be blocked produces a take strobe one edge later, or an eligible one is refused. The level is also visible on `cur_mask` from the edge after it changes. A fault in the entry sequencing shows up on the edge after `ctx_pushed`. The committed level differs from the winner's level plus one, or `in_entry` fails to drop, or a mask write made during entry leaks through. Mis-ranked requests show as a wrong `vec_idx` and `vec_addr` in the single cycle that `take_int` is high.

// File: rtl/irqlc_pkg.sv
// Shared encodings for the interrupt level controller.
// Assumes: mask operation codes are fixed by the CPU decoder.
package irqlc_pkg;
    typedef enum logic [2:0] {
        MOP_NONE    = 3'd0,
        MOP_LOAD    = 3'd1,
        MOP_AND     = 3'd2,
        MOP_OR      = 3'd3,
        MOP_RESTORE = 3'd4
    } mask_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ENTRY = 1'b1
    } entry_st_e;
endpackage

// File: rtl/irqlc_arbiter.sv
// Priority arbiter: finds the highest eligible request level.
// Assumes: level NUM_HW is unmaskable; level i < NUM_HW is eligible when
// i >= mask (its servicing level i+1 is above the mask).
module irqlc_arbiter #(
    parameter int NUM_HW = 7,
    parameter int LVL_W  = $clog2(NUM_HW + 1)
) (
    input  logic [NUM_HW:0]    req,
    input  logic [LVL_W-1:0]   mask,
    output logic               hit,
    output logic [LVL_W-1:0]   win
);
    logic [NUM_HW:0] eligible;

    // Per-level eligibility; the top level bypasses the mask.
    for (genvar i = 0; i <= NUM_HW; i++) begin : g_elig
        if (i == NUM_HW) begin : g_top
            assign eligible[i] = req[i];
        end else begin : g_mask
            assign eligible[i] = req[i] && (LVL_W'(i) >= mask);
        end
    end

    // Highest-numbered eligible level wins.
    always_comb begin
        win = '0;
        for (int j = 0; j <= NUM_HW; j++) begin
            if (eligible[j]) win = LVL_W'(j);
        end
    end

    assign hit = |eligible;
endmodule

// File: rtl/irqlc_mask_reg.sv
// Servicing-level register with software operations and entry commit.
// Assumes: commit and op_en never coincide (commit only during entry,
// op_en only outside it); commit still takes precedence.
module irqlc_mask_reg
    import irqlc_pkg::*;
#(
    parameter int LVL_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_en,
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] data,
    input  logic              commit,
    input  logic [LVL_W-1:0]  commit_lvl,
    output logic [LVL_W-1:0]  mask
);
    logic [LVL_W-1:0] operand;
    assign operand = data[LVL_W-1:0];

    // Level register update: reset to all ones, commit, or software op.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (commit) begin
            mask <= commit_lvl;
        end else if (op_en) begin
            case (mask_op_e'(op))
                MOP_LOAD, MOP_RESTORE: mask <= operand;
                MOP_AND:               mask <= mask & operand;
                MOP_OR:                mask <= mask | operand;
                default:               mask <= mask;
            endcase
        end
    end
endmodule

// File: rtl/irqlc_entry_fsm.sv
// Entry sequencer: accepts a request at a boundary, strobes take, holds
// the pending level until the CPU reports the context push.
// Assumes: swi_req is held until taken; hardware wins over software.
module irqlc_entry_fsm
    import irqlc_pkg::*;
#(
    parameter int NUM_HW = 7,
    parameter int LVL_W  = 3,
    parameter int VEC_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_rdy,
    input  logic             hw_hit,
    input  logic [LVL_W-1:0] hw_lvl,
    input  logic             swi_req,
    input  logic [VEC_W-1:0] swi_vec,
    input  logic             ctx_pushed,
    input  logic [LVL_W-1:0] cur_mask,
    output logic             in_entry,
    output logic             take_int,
    output logic [VEC_W-1:0] vec_idx,
    output logic             src_hw,
    output logic             commit,
    output logic [LVL_W-1:0] commit_lvl
);
    entry_st_e        st;
    logic [LVL_W-1:0] pend_lvl;
    logic             accept;

    assign accept = (st == ST_IDLE) && fetch_rdy && (hw_hit || swi_req);

    // Sequencer state, take strobe and captured vector / level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            take_int <= 1'b0;
            vec_idx  <= '0;
            src_hw   <= 1'b0;
            pend_lvl <= '1;
        end else begin
            take_int <= accept;
            if (accept) begin
                st <= ST_ENTRY;
                if (hw_hit) begin
                    vec_idx  <= VEC_W'(hw_lvl);
                    src_hw   <= 1'b1;
                    pend_lvl <= (hw_lvl == LVL_W'(NUM_HW)) ? '1 : hw_lvl + 1'b1;
                end else begin
                    vec_idx  <= swi_vec;
                    src_hw   <= 1'b0;
                end
            end else if (st == ST_ENTRY && ctx_pushed) begin
                st <= ST_IDLE;
            end
        end
    end

    assign in_entry   = (st == ST_ENTRY);
    assign commit     = in_entry && ctx_pushed;
    assign commit_lvl = src_hw ? pend_lvl : cur_mask;

    // R5: take strobe never lasts longer than one cycle.
    a_r5_take_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |=> !take_int);

    // R5: entry only starts from a boundary.
    a_r5_entry_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_entry) |-> $past(fetch_rdy));
endmodule

// File: rtl/irq_level_ctrl.sv
// Top of the interrupt level controller: arbiter, entry sequencer and
// servicing-level register. Vector table occupies the top 16 words.
// Assumes: synchronous active-low reset; level NUM_HW is the reset level.
module irq_level_ctrl #(
    parameter int NUM_HW = 7,
    parameter int VEC_W  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int LVL_W  = $clog2(NUM_HW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_HW-1:0] irq_req,
    input  logic              rst_req,
    input  logic              fetch_rdy,
    input  logic              swi_req,
    input  logic [VEC_W-1:0]  swi_vec,
    input  logic [2:0]        mask_op,
    input  logic [DATA_W-1:0] mask_data,
    input  logic              ctx_pushed,
    output logic              take_int,
    output logic [VEC_W-1:0]  vec_idx,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [LVL_W-1:0]  cur_mask,
    output logic              in_entry
);
    localparam int PAD_W = ADDR_W - VEC_W - 1;

    logic             hw_hit;
    logic [LVL_W-1:0] hw_lvl;
    logic             src_hw;
    logic             commit;
    logic [LVL_W-1:0] commit_lvl;

    irqlc_arbiter #(.NUM_HW(NUM_HW), .LVL_W(LVL_W)) u_arb (
        .req  ({rst_req, irq_req}),
        .mask (cur_mask),
        .hit  (hw_hit),
        .win  (hw_lvl)
    );

    irqlc_entry_fsm #(.NUM_HW(NUM_HW), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_rdy  (fetch_rdy),
        .hw_hit     (hw_hit),
        .hw_lvl     (hw_lvl),
        .swi_req    (swi_req),
        .swi_vec    (swi_vec),
        .ctx_pushed (ctx_pushed),
        .cur_mask   (cur_mask),
        .in_entry   (in_entry),
        .take_int   (take_int),
        .vec_idx    (vec_idx),
        .src_hw     (src_hw),
        .commit     (commit),
        .commit_lvl (commit_lvl)
    );

    irqlc_mask_reg #(.LVL_W(LVL_W), .DATA_W(DATA_W)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_en      (!in_entry),
        .op         (mask_op),
        .data       (mask_data),
        .commit     (commit),
        .commit_lvl (commit_lvl),
        .mask       (cur_mask)
    );

    // Vector word address inside the top 16 words of the space.
    assign vec_addr = {{PAD_W{1'b1}}, vec_idx, 1'b0};

    // Level expected after a hardware commit, derived from the vector.
    logic [LVL_W-1:0] exp_hw_lvl;
    assign exp_hw_lvl = (vec_idx == VEC_W'(NUM_HW)) ? '1 : LVL_W'(vec_idx) + 1'b1;

    // R1: reset leaves the mask fully raised and the sequencer idle.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (cur_mask == '1) && !in_entry && !take_int);

    // R2: a hardware take is never below the mask in force at the boundary.
    a_r2_take_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (take_int && src_hw) |->
            (vec_idx == VEC_W'(NUM_HW)) || (vec_idx >= VEC_W'($past(cur_mask))));

    // R6: commit of a hardware entry sets the level from the taken vector.
    a_r6_commit_level: assert property (@(posedge clk) disable iff (!rst_n)
        (in_entry && ctx_pushed && src_hw) |=> (cur_mask == $past(exp_hw_lvl)));

    // R7: a software entry commit leaves the level untouched.
    a_r7_soft_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (in_entry && ctx_pushed && !src_hw) |=> $stable(cur_mask));

    // R9: while waiting for the push, the level cannot move.
    a_r9_frozen_in_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (in_entry && !ctx_pushed) |=> $stable(cur_mask) && in_entry);
endmodule

// File: tb/tb_irq_level_ctrl.sv
module tb_irq_level_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  irq_req;
    logic        rst_req;
    logic        fetch_rdy;
    logic        swi_req;
    logic [3:0]  swi_vec;
    logic [2:0]  mask_op;
    logic [7:0]  mask_data;
    logic        ctx_pushed;
    logic        take_int;
    logic [3:0]  vec_idx;
    logic [15:0] vec_addr;
    logic [2:0]  cur_mask;
    logic        in_entry;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    irq_level_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .rst_req(rst_req),
        .fetch_rdy(fetch_rdy), .swi_req(swi_req), .swi_vec(swi_vec),
        .mask_op(mask_op), .mask_data(mask_data), .ctx_pushed(ctx_pushed),
        .take_int(take_int), .vec_idx(vec_idx), .vec_addr(vec_addr),
        .cur_mask(cur_mask), .in_entry(in_entry)
    );

    // Vector: {pre_mask[3], req8[8], swi[1], svec[4], take[1], vec[4], mask_after[3]}
    localparam int NV = 12;
    localparam logic [23:0] VEC_TBL [NV] = '{
        {3'd0, 8'h01, 1'b0, 4'd0,  1'b1, 4'd0,  3'd1},
        {3'd0, 8'h41, 1'b0, 4'd0,  1'b1, 4'd6,  3'd7},
        {3'd3, 8'h04, 1'b0, 4'd0,  1'b0, 4'd0,  3'd3},
        {3'd3, 8'h08, 1'b0, 4'd0,  1'b1, 4'd3,  3'd4},
        {3'd7, 8'h7F, 1'b0, 4'd0,  1'b0, 4'd0,  3'd7},
        {3'd7, 8'h80, 1'b0, 4'd0,  1'b1, 4'd7,  3'd7},
        {3'd5, 8'h9F, 1'b0, 4'd0,  1'b1, 4'd7,  3'd7},
        {3'd2, 8'h26, 1'b0, 4'd0,  1'b1, 4'd5,  3'd6},
        {3'd0, 8'h00, 1'b1, 4'd12, 1'b1, 4'd12, 3'd0},
        {3'd4, 8'h10, 1'b1, 4'd9,  1'b1, 4'd4,  3'd5},
        {3'd6, 8'h02, 1'b1, 4'd3,  1'b1, 4'd3,  3'd6},
        {3'd1, 8'h00, 1'b0, 4'd0,  1'b0, 4'd0,  3'd1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        irq_req = '0; rst_req = 1'b0; fetch_rdy = 1'b0; swi_req = 1'b0;
        swi_vec = '0; mask_op = 3'd0; mask_data = '0; ctx_pushed = 1'b0;
    endtask

    task automatic set_mask(input logic [2:0] m);
        mask_op = 3'd1; mask_data = {5'b0, m};
        tick();
        mask_op = 3'd0;
    endtask

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        tick(); tick();
        // R1: reset state
        chk(cur_mask == 3'b111, "R1 mask", cur_mask, 7);
        chk(!take_int && !in_entry, "R1 idle", {take_int, in_entry}, 0);
        rst_n = 1'b1;
        tick();

        // Vector table walk: R2 R3 R4 R6 R7
        for (int k = 0; k < NV; k++) begin
            logic [23:0] v;
            v = VEC_TBL[k];
            set_mask(v[23:21]);
            chk(cur_mask == v[23:21], "R8 preset", cur_mask, v[23:21]);
            irq_req = v[19:13]; rst_req = v[20];
            swi_req = v[12]; swi_vec = v[11:8];
            fetch_rdy = 1'b1;
            tick();
            idle_inputs();
            chk(take_int == v[7], "R2/R3 take", take_int, v[7]);
            if (v[7]) begin
                chk(vec_idx == v[6:3], "R4/R7 vector", vec_idx, v[6:3]);
                chk(vec_addr == 16'hFFE0 + 16'(v[6:3]) * 2, "R4 addr", vec_addr,
                    16'hFFE0 + 16'(v[6:3]) * 2);
                chk(cur_mask == v[23:21], "R6 unchanged at take", cur_mask, v[23:21]);
                ctx_pushed = 1'b1;
                tick();
                ctx_pushed = 1'b0;
                chk(!in_entry, "R6 entry done", in_entry, 0);
            end
            chk(cur_mask == v[2:0], "R6/R7 level after", cur_mask, v[2:0]);
        end

        // R5: no sampling without fetch_rdy; one-cycle strobe
        set_mask(3'd0);
        irq_req = 7'h7F;
        tick(); tick();
        chk(!take_int && !in_entry, "R5 no boundary", take_int, 0);
        fetch_rdy = 1'b1;
        tick();
        fetch_rdy = 1'b0;
        chk(take_int && vec_idx == 4'd6, "R5 take", vec_idx, 6);
        tick();
        chk(!take_int && in_entry, "R5 pulse width", take_int, 0);

        // R9: ops and boundaries ignored in entry
        mask_op = 3'd1; mask_data = 8'h02; fetch_rdy = 1'b1; rst_req = 1'b1;
        tick();
        mask_op = 3'd0; fetch_rdy = 1'b0; rst_req = 1'b0; irq_req = '0;
        chk(cur_mask == 3'd0, "R9 op in entry", cur_mask, 0);
        chk(!take_int, "R9 boundary in entry", take_int, 0);
        ctx_pushed = 1'b1;
        tick();
        ctx_pushed = 1'b0;
        chk(cur_mask == 3'd7, "R6 IRQ6 commit", cur_mask, 7);
        ctx_pushed = 1'b1;
        tick();
        ctx_pushed = 1'b0;
        chk(cur_mask == 3'd7 && !in_entry, "R9 push outside entry", cur_mask, 7);

        // R8: operations
        set_mask(3'd6);
        mask_op = 3'd2; mask_data = 8'h03; tick();
        chk(cur_mask == 3'd2, "R8 and", cur_mask, 2);
        mask_op = 3'd3; mask_data = 8'h05; tick();
        chk(cur_mask == 3'd7, "R8 or", cur_mask, 7);
        mask_op = 3'd4; mask_data = 8'hF3; tick();
        chk(cur_mask == 3'd3, "R8 restore", cur_mask, 3);
        mask_op = 3'd6; mask_data = 8'h00; tick();
        chk(cur_mask == 3'd3, "R8 unused code", cur_mask, 3);
        mask_op = 3'd0;

        // R10: same-cycle op and boundary
        set_mask(3'd5);
        irq_req = 7'h10; fetch_rdy = 1'b1; mask_op = 3'd1; mask_data = 8'h00;
        tick();
        mask_op = 3'd0;
        chk(!take_int && cur_mask == 3'd0, "R10 old mask decides", take_int, 0);
        tick();
        fetch_rdy = 1'b0; irq_req = '0;
        chk(take_int && vec_idx == 4'd4, "R10 next boundary", vec_idx, 4);

        // R1: reset in mid-entry
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk(!in_entry && cur_mask == 3'd7, "R1 reset in entry", cur_mask, 7);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule